// File: doc/BRIEF.md
# Keyed Restart Watchdog Timer

This peripheral is a watchdog on a plain 32-bit register bus. A strobe, a write flag, a 3-bit word address and write data select one of eight word registers, and read data returns the addressed register combinationally. The block holds a down-counter that software reloads by writing a fixed 16-bit key. While counting is enabled, the counter steps either on every bus clock or on a roughly 1 MHz tick-enable input, as a control bit selects.

When the counter is at zero and takes a step, the count has expired. Expiry sets a sticky timeout flag. If reset on timeout is enabled, the block then raises a reset request for a programmable number of bus clocks. While that request is high, the block also presents a reset-scope code, a 26-bit peripheral reset mask and a second-boot sideband flag. The chip's reset controller consumes these outputs.

Word offsets, in order: 0 live count (read-only), 1 reload value, 2 restart, 3 control, 4 timeout status, 5 timeout clear, 6 reset pulse width, 7 reset mask. Control fields: bit 0 count enable, bit 1 reset on timeout, bit 4 tick select, bits 6:5 reset scope (0 SoC, 1 whole chip, 2 CPU only, 3 reserved), bit 7 second-boot flag.

Top module: `bus_watchdog`

## Requirements
- R1: After reset, the reload value and the count are both 0x00FFFFFF, control reads 0, timeout status reads 0, reset width reads 0xFF, and reset mask reads 0x03FFFFFF. The outputs reset_req, reset_scope, reset_mask and second_boot are all 0.
- R2: Reads return the register at the given word offset, with unused bits as zero. The control register reads back only bits 0, 1, 4, 5, 6 and 7. The restart register (offset 2) and the clear register (offset 5) read as 0. A write to the count register (offset 0) has no effect.
- R3: A write of exactly 0x00004755 to offset 2 loads the count from the reload value on that clock edge. Any other value written there leaves the count unchanged.
- R4: With control bit 0 set and bit 4 clear, the count falls by one on every bus clock. With bit 0 clear, the count holds its value.
- R5: With control bits 0 and 4 both set, the count falls by one only on a clock where tick is high.
- R6: A step taken while the count is 0 is an expiry, and it sets timeout status bit 0. If control bit 1 is clear, the same edge reloads the count and reset_req stays low.
- R7: On expiry with control bit 1 set, reset_req rises at that edge and stays high for W bus clocks, where W is the width register value (a value of 0 counts as 1). The edge that drops reset_req reloads the count.
- R8: While reset_req is high, reset_scope carries control bits 6:5, reset_mask carries the mask register, and second_boot carries control bit 7. All three are 0 while reset_req is low.
- R9: A write of any value to offset 5 clears timeout status bit 0. When that write and an expiry fall on the same edge, the status stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | About 1 MHz count enable, one clock wide |
| bus_sel | input | 1 | Access strobe |
| bus_write | input | 1 | High for a write, low for a read |
| bus_addr | input | 3 | Word offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| reset_req | output | 1 | Timeout reset request |
| reset_scope | output | 2 | Reset scope code, valid with reset_req |
| reset_mask | output | 26 | Peripheral reset selection, valid with reset_req |
| second_boot | output | 1 | Second-boot flag, valid with reset_req |

## Verification
Two conflicts can occur on the same clock edge. The first is a status clear that coincides with an expiry. The bench sets the reload value to zero with reset disabled, so that every bus clock is an expiry. Any clear write then collides with one, and the status must still read 1 afterwards. The second conflict is a restart that lands while the counter is stepping. The bench issues the restart mid-count and judges it by whether the count reads exactly the reload value afterwards, and not that value minus one.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned OFS_W  = 3;

  localparam logic [OFS_W-1:0] OFS_COUNT   = 3'd0;
  localparam logic [OFS_W-1:0] OFS_RELOAD  = 3'd1;
  localparam logic [OFS_W-1:0] OFS_RESTART = 3'd2;
  localparam logic [OFS_W-1:0] OFS_CTRL    = 3'd3;
  localparam logic [OFS_W-1:0] OFS_STATUS  = 3'd4;
  localparam logic [OFS_W-1:0] OFS_CLEAR   = 3'd5;
  localparam logic [OFS_W-1:0] OFS_WIDTH   = 3'd6;
  localparam logic [OFS_W-1:0] OFS_MASK    = 3'd7;

  localparam int unsigned CB_EN    = 0;
  localparam int unsigned CB_RST   = 1;
  localparam int unsigned CB_TICK  = 4;
  localparam int unsigned CB_SCOPE = 5;
  localparam int unsigned CB_BOOT  = 7;

  typedef struct packed {
    logic       boot;
    logic [1:0] scope;
    logic       tick_sel;
    logic       rst_en;
    logic       en;
  } ctrl_t;
endpackage

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int unsigned CNT_W    = 32,
  parameter int unsigned WID_W    = 8,
  parameter logic [CNT_W-1:0] CNT_INIT = 32'h00FF_FFFF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             tick_sel,
  input  logic             tick,
  input  logic             rst_en,
  input  logic             restart,
  input  logic [CNT_W-1:0] reload,
  input  logic [WID_W-1:0] width,
  output logic [CNT_W-1:0] count,
  output logic             pulse,
  output logic             expire
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [WID_W-1:0] pc_q, pc_d;
  logic             pul_q, pul_d;
  logic             step;

  always_comb begin
    step   = enable & (tick_sel ? tick : 1'b1);
    expire = step & ~pul_q & (cnt_q == '0);
    cnt_d  = cnt_q;
    pc_d   = pc_q;
    pul_d  = pul_q;
    if (pul_q) begin
      if (pc_q <= WID_W'(1)) begin
        pul_d = 1'b0;
        cnt_d = reload;
      end else begin
        pc_d = pc_q - WID_W'(1);
      end
    end else if (step) begin
      if (cnt_q == '0) begin
        if (rst_en) begin
          pul_d = 1'b1;
          pc_d  = (width == '0) ? WID_W'(1) : width;
        end else begin
          cnt_d = reload;
        end
      end else begin
        cnt_d = cnt_q - CNT_W'(1);
      end
    end
    if (restart) cnt_d = reload;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= CNT_INIT;
      pc_q  <= '0;
      pul_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      pc_q  <= pc_d;
      pul_q <= pul_d;
    end
  end

  assign count = cnt_q;
  assign pulse = pul_q;

  // R3
  restart_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt_q == $past(reload)));
  // R4
  hold_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && !restart && !pul_q) |=> $stable(cnt_q));
  // R7
  pulse_end_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pul_q) |-> (cnt_q == $past(reload)));
endmodule

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned WID_W  = 8,
  parameter int unsigned MASK_W = 26,
  parameter logic [15:0] KEY    = 16'h4755,
  parameter logic [CNT_W-1:0] RELOAD_INIT = 32'h00FF_FFFF,
  parameter logic [WID_W-1:0] WIDTH_INIT  = 8'hFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              wr,
  input  logic [OFS_W-1:0]  addr,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata,
  input  logic [CNT_W-1:0]  count,
  input  logic              expire,
  output logic              restart,
  output ctrl_t             ctrl,
  output logic [CNT_W-1:0]  reload,
  output logic [WID_W-1:0]  width,
  output logic [MASK_W-1:0] mask
);
  logic              wstb;
  logic              clr_wr;
  ctrl_t             ctrl_q, ctrl_d;
  logic [CNT_W-1:0]  rel_q, rel_d;
  logic [WID_W-1:0]  wid_q, wid_d;
  logic [MASK_W-1:0] msk_q, msk_d;
  logic              st_q, st_d;

  always_comb begin
    wstb    = sel & wr;
    clr_wr  = wstb & (addr == OFS_CLEAR);
    restart = wstb & (addr == OFS_RESTART) & (wdata == {16'h0, KEY});
    ctrl_d  = ctrl_q;
    rel_d   = rel_q;
    wid_d   = wid_q;
    msk_d   = msk_q;
    if (wstb) begin
      case (addr)
        OFS_RELOAD: rel_d = wdata[CNT_W-1:0];
        OFS_CTRL: begin
          ctrl_d.en       = wdata[CB_EN];
          ctrl_d.rst_en   = wdata[CB_RST];
          ctrl_d.tick_sel = wdata[CB_TICK];
          ctrl_d.scope    = wdata[CB_SCOPE+1:CB_SCOPE];
          ctrl_d.boot     = wdata[CB_BOOT];
        end
        OFS_WIDTH: wid_d = wdata[WID_W-1:0];
        OFS_MASK:  msk_d = wdata[MASK_W-1:0];
        default: ;
      endcase
    end
    if (expire)      st_d = 1'b1;
    else if (clr_wr) st_d = 1'b0;
    else             st_d = st_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      rel_q  <= RELOAD_INIT;
      wid_q  <= WIDTH_INIT;
      msk_q  <= '1;
      st_q   <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      rel_q  <= rel_d;
      wid_q  <= wid_d;
      msk_q  <= msk_d;
      st_q   <= st_d;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      OFS_COUNT:  rdata[CNT_W-1:0] = count;
      OFS_RELOAD: rdata[CNT_W-1:0] = rel_q;
      OFS_CTRL: begin
        rdata[CB_EN]                = ctrl_q.en;
        rdata[CB_RST]               = ctrl_q.rst_en;
        rdata[CB_TICK]              = ctrl_q.tick_sel;
        rdata[CB_SCOPE+1:CB_SCOPE]  = ctrl_q.scope;
        rdata[CB_BOOT]              = ctrl_q.boot;
      end
      OFS_STATUS: rdata[0] = st_q;
      OFS_WIDTH:  rdata[WID_W-1:0] = wid_q;
      OFS_MASK:   rdata[MASK_W-1:0] = msk_q;
      default: ;
    endcase
  end

  assign ctrl   = ctrl_q;
  assign reload = rel_q;
  assign width  = wid_q;
  assign mask   = msk_q;

  // R6
  expiry_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> st_q);
  // R9
  clear_drops_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && !expire) |=> !st_q);
endmodule

// File: rtl/bus_watchdog.sv
module bus_watchdog
  import wdog_pkg::*;
#(
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned WID_W  = 8,
  parameter int unsigned MASK_W = 26
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              bus_sel,
  input  logic              bus_write,
  input  logic [2:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              reset_req,
  output logic [1:0]        reset_scope,
  output logic [MASK_W-1:0] reset_mask,
  output logic              second_boot
);
  localparam logic [CNT_W-1:0] RELOAD_INIT = CNT_W'(32'h00FF_FFFF);

  ctrl_t             ctrl;
  logic              restart, expire, pulse;
  logic [CNT_W-1:0]  reload, count;
  logic [WID_W-1:0]  width;
  logic [MASK_W-1:0] mask;

  wdog_regs #(
    .CNT_W(CNT_W), .WID_W(WID_W), .MASK_W(MASK_W),
    .KEY(16'h4755), .RELOAD_INIT(RELOAD_INIT), .WIDTH_INIT('1)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .sel(bus_sel), .wr(bus_write),
    .addr(bus_addr), .wdata(bus_wdata), .rdata(bus_rdata),
    .count(count), .expire(expire), .restart(restart), .ctrl(ctrl),
    .reload(reload), .width(width), .mask(mask)
  );

  wdog_counter #(
    .CNT_W(CNT_W), .WID_W(WID_W), .CNT_INIT(RELOAD_INIT)
  ) u_cnt (
    .clk(clk), .rst_n(rst_n), .enable(ctrl.en), .tick_sel(ctrl.tick_sel),
    .tick(tick), .rst_en(ctrl.rst_en), .restart(restart), .reload(reload),
    .width(width), .count(count), .pulse(pulse), .expire(expire)
  );

  always_comb begin
    reset_req   = pulse;
    reset_scope = pulse ? ctrl.scope : 2'b00;
    reset_mask  = pulse ? mask : '0;
    second_boot = pulse & ctrl.boot;
  end

  // R7
  req_needs_expiry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reset_req) |-> $past(expire));
endmodule

// File: tb/bus_watchdog_tb.sv
module bus_watchdog_tb;
  localparam time PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n, tick, bus_sel, bus_write;
  logic [2:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        reset_req, second_boot;
  logic [1:0]  reset_scope;
  logic [25:0] reset_mask;

  int checks = 0;
  int errors = 0;

  always #(PERIOD/2) clk = ~clk;

  bus_watchdog u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bus_sel(bus_sel),
    .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .reset_req(reset_req), .reset_scope(reset_scope),
    .reset_mask(reset_mask), .second_boot(second_boot)
  );

  // {is_read, tag, addr, data, expected}
  localparam int NV = 20;
  localparam logic [71:0] VEC [NV] = '{
    {1'b1, 4'd1, 3'd0, 32'h0,          32'h00FF_FFFF},  // R1
    {1'b1, 4'd1, 3'd1, 32'h0,          32'h00FF_FFFF},  // R1
    {1'b1, 4'd1, 3'd3, 32'h0,          32'h0},          // R1
    {1'b1, 4'd1, 3'd4, 32'h0,          32'h0},          // R1
    {1'b1, 4'd1, 3'd6, 32'h0,          32'h0000_00FF},  // R1
    {1'b1, 4'd1, 3'd7, 32'h0,          32'h03FF_FFFF},  // R1
    {1'b0, 4'd2, 3'd1, 32'h0000_0010,  32'h0},
    {1'b1, 4'd2, 3'd1, 32'h0,          32'h0000_0010},  // R2
    {1'b1, 4'd3, 3'd0, 32'h0,          32'h00FF_FFFF},  // R3 no load yet
    {1'b0, 4'd3, 3'd2, 32'h0000_1234,  32'h0},
    {1'b1, 4'd3, 3'd0, 32'h0,          32'h00FF_FFFF},  // R3 wrong key
    {1'b0, 4'd3, 3'd2, 32'h0000_4755,  32'h0},
    {1'b1, 4'd3, 3'd0, 32'h0,          32'h0000_0010},  // R3 key loads
    {1'b0, 4'd2, 3'd0, 32'h0000_0005,  32'h0},
    {1'b1, 4'd2, 3'd0, 32'h0,          32'h0000_0010},  // R2 read-only
    {1'b0, 4'd2, 3'd6, 32'hFFFF_FF03,  32'h0},
    {1'b1, 4'd2, 3'd6, 32'h0,          32'h0000_0003},  // R2 reserved
    {1'b1, 4'd2, 3'd2, 32'h0,          32'h0},          // R2
    {1'b1, 4'd2, 3'd5, 32'h0,          32'h0},          // R2
    {1'b1, 4'd2, 3'd7, 32'h0,          32'h03FF_FFFF}   // R2
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int highs;
    rst_n = 1'b0; tick = 1'b0; bus_sel = 1'b0; bus_write = 1'b0;
    bus_addr = '0; bus_wdata = '0;
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    check("R1 reset_req", {31'h0, reset_req}, 32'h0);
    check("R1 reset_mask out", {6'h0, reset_mask}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][71]) begin
        rd(VEC[i][66:64], v);
        check($sformatf("R%0d vector %0d", VEC[i][70:67], i), v, VEC[i][31:0]);
      end else begin
        wr(VEC[i][66:64], VEC[i][63:32]);
      end
    end

    // R2 control readback of all fields, reserved bits zero
    wr(3'd3, 32'hFFFF_FFFF);
    rd(3'd3, v);
    check("R2 ctrl readback", v, 32'h0000_00F3);
    wr(3'd3, 32'h0);

    // R4 bus-clock counting, R6 expiry without reset
    wr(3'd1, 32'd3);
    wr(3'd2, 32'h4755);
    wr(3'd3, 32'h1);
    rd(3'd0, v); check("R4 count start", v, 32'd3);
    cyc(1); rd(3'd0, v); check("R4 count step", v, 32'd2);
    cyc(3);
    rd(3'd0, v); check("R6 reload after expiry", v, 32'd3);
    rd(3'd4, v); check("R6 status set", v, 32'd1);
    check("R6 no reset_req", {31'h0, reset_req}, 32'h0);
    wr(3'd3, 32'h0);
    rd(3'd0, v);
    cyc(4);
    begin
      logic [31:0] v2;
      rd(3'd0, v2);
      check("R4 hold when disabled", v2, v);
    end
    wr(3'd5, 32'h0);
    rd(3'd4, v); check("R9 clear alone", v, 32'd0);

    // R5 tick-enabled counting
    wr(3'd1, 32'd5);
    wr(3'd2, 32'h4755);
    wr(3'd3, 32'h11);
    cyc(10);
    rd(3'd0, v); check("R5 no tick no step", v, 32'd5);
    tick = 1'b1; @(negedge clk); tick = 1'b0;
    rd(3'd0, v); check("R5 one tick one step", v, 32'd4);
    wr(3'd3, 32'h0);

    // R7/R8 reset pulse of width 3
    wr(3'd1, 32'd2);
    wr(3'd6, 32'd3);
    wr(3'd7, 32'h0000_0005);
    wr(3'd2, 32'h4755);
    wr(3'd3, 32'h0000_00C3);
    highs = 0;
    for (int i = 1; i <= 6; i++) begin
      @(negedge clk); #1;
      if (reset_req) begin
        highs++;
        check("R8 scope", {30'h0, reset_scope}, 32'd2);
        check("R8 mask", {6'h0, reset_mask}, 32'h5);
        check("R8 second_boot", {31'h0, second_boot}, 32'd1);
      end else if (i == 1) begin
        check("R8 mask idle", {6'h0, reset_mask}, 32'h0);
        check("R8 boot idle", {31'h0, second_boot}, 32'h0);
      end
      if (i == 6) begin
        rd(3'd0, v); check("R7 reload at pulse end", v, 32'd2);
      end
    end
    check("R7 pulse length", highs, 32'd3);
    wr(3'd3, 32'h0);
    cyc(4);

    // R7 width 0 acts as 1
    wr(3'd6, 32'd0);
    wr(3'd1, 32'd0);
    wr(3'd2, 32'h4755);
    wr(3'd3, 32'h3);
    @(negedge clk); #1;
    check("R7 width0 high", {31'h0, reset_req}, 32'd1);
    @(negedge clk); #1;
    check("R7 width0 one cycle", {31'h0, reset_req}, 32'd0);
    wr(3'd3, 32'h0);
    cyc(3);

    // R9 clear collides with expiry every cycle
    wr(3'd3, 32'h1);
    wr(3'd5, 32'h0);
    rd(3'd4, v); check("R9 expiry wins", v, 32'd1);
    wr(3'd3, 32'h0);
    wr(3'd5, 32'h0);
    rd(3'd4, v); check("R9 clear after stop", v, 32'd0);

    // R3 restart in the middle of counting
    wr(3'd1, 32'd100);
    wr(3'd2, 32'h4755);
    wr(3'd3, 32'h1);
    cyc(5);
    wr(3'd2, 32'h4755);
    rd(3'd0, v); check("R3 restart mid-count", v, 32'd100);
    wr(3'd3, 32'h0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule